// File: doc/BRIEF.md
# Coalescing Interrupt Controller

This block collects twelve single-cycle event pulses from the rest of a device into a sticky cause register, gates them with a mask, and drives one interrupt request line. Software reads the cause register to find out what happened and acknowledges bits by writing ones to them. A write-only force register lets test software set any cause bit directly, without the hardware event having to occur.

Interrupt traffic is reduced by coalescing. Every unmasked event that arrives adds one to a pending count. The interrupt pulses when that count reaches a programmed threshold, or when the oldest pending event has waited a programmed number of microsecond ticks, whichever comes first. Both the count and the timer then restart. The microsecond time base is a one-cycle strobe supplied from outside the block.

Registers sit on a small word-addressed bus. Writes happen on one clock edge and reads are combinational. Word 0 is the cause register, word 1 the mask, word 2 the force register and word 3 the coalescing configuration.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: Cause word 0 holds one sticky bit per source (bit i for event i, i = 0..11). Writing a 1 to a bit clears it and writing a 0 leaves it alone. Bits 31:12 always read zero and writes to them do nothing.
- R2: Mask word 1 resets to 0xFFFFFFFF and reads back what was written. A mask bit of 1 blocks its source from the pending count and the interrupt, but the source still sets its cause bit. A mask bit of 0 enables the source.
- R3: A write of value n to force word 2 sets cause bit n when n < 12 and counts as an event of that source. A value of n ≥ 12 changes nothing. Word 2 reads zero.
- R4: Coalescing word 3 resets to 0x00010001. Bits 15:0 are the delay limit in microsecond ticks and bits 31:16 are the count limit.
- R5: When an event for a bit and a write-one-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R6: The interrupt pulses once when the running total of unmasked events reaches the count limit. Several events in one cycle each add one. A count limit of 0 or 1 makes every cycle that has an unmasked event raise the interrupt.
- R7: While events are pending, each tick advances a timer that starts at the cycle after the first pending event. The interrupt pulses on the tick that brings the timer to the delay limit, and a limit of 0 acts as 1. Ticks do nothing while no event is pending.
- R8: A pulse clears both the pending count and the timer. Events that arrive in the cycle of the pulse are absorbed by it and are not carried over.
- R9: Clearing a mask bit whose cause bit is already set counts as one new event of that source.
- R10: The interrupt output is high for exactly the one cycle that follows the clock edge at which the triggering event or tick is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word index: 0 cause, 1 mask, 2 force, 3 coalescing |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| evt_pulse | input | 12 | One-cycle event pulses, one per source |
| us_tick | input | 1 | One-cycle microsecond strobe |
| irq | output | 1 | Coalesced interrupt pulse |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a hardware event and a software write-one-to-clear aimed at the same cause bit. The bench drives the event pulse and the clearing write in one cycle, then reads the cause word, expecting the event bit still set and a neighbouring bit cleared. The second pair is the count and the timer acting on the same pending state. In these runs an event arrives in the cycle that fires the interrupt, or the count fires while the timer is running, and the bench checks that the next timeout is measured from a fresh start and that no leftover count fires early.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    SEL_CAUSE = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_FORCE = 2'd2,
    SEL_COAL  = 2'd3
  } reg_sel_e;

  localparam logic [31:0] MASK_RST_VAL = 32'hFFFF_FFFF;
  localparam logic [31:0] COAL_RST_VAL = 32'h0001_0001;

  // Number of set bits in a vector of up to 32 bits.
  function automatic logic [5:0] count_ones(input logic [31:0] v);
    logic [5:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + {5'd0, v[i]};
    return n;
  endfunction

  // A limit of zero behaves as one.
  function automatic logic [16:0] eff_limit(input logic [15:0] lim);
    return (lim == 16'd0) ? 17'd1 : {1'b0, lim};
  endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NSRC   = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NSRC-1:0]   cause_q,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NSRC-1:0]   w1c_vec,
  output logic [NSRC-1:0]   force_vec,
  output logic [NSRC-1:0]   mask_src,
  output logic [NSRC-1:0]   unmask_vec,
  output logic [DATA_W/2-1:0] max_cnt,
  output logic [DATA_W/2-1:0] max_dly
);
  localparam int HALF_W = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);

  logic [DATA_W-1:0] mask_q, coal_q;
  logic wr_cause, wr_mask, wr_force, wr_coal;

  assign wr_cause = reg_wr && (reg_addr == SEL_CAUSE);
  assign wr_mask  = reg_wr && (reg_addr == SEL_MASK);
  assign wr_force = reg_wr && (reg_addr == SEL_FORCE);
  assign wr_coal  = reg_wr && (reg_addr == SEL_COAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST_VAL;
      coal_q <= COAL_RST_VAL;
    end else begin
      if (wr_mask) mask_q <= reg_wdata;
      if (wr_coal) coal_q <= reg_wdata;
    end
  end

  assign mask_src = mask_q[NSRC-1:0];
  assign max_dly  = coal_q[HALF_W-1:0];
  assign max_cnt  = coal_q[DATA_W-1:HALF_W];
  assign w1c_vec  = wr_cause ? reg_wdata[NSRC-1:0] : '0;
  assign unmask_vec = wr_mask ? (mask_q[NSRC-1:0] & ~reg_wdata[NSRC-1:0]) : '0;

  // Force decodes a bit position; positions past the last source do nothing.
  logic upper_zero;
  assign upper_zero = (reg_wdata[DATA_W-1:IDX_W] == '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_force
    assign force_vec[g] = wr_force && upper_zero && (reg_wdata[IDX_W-1:0] == IDX_W'(g));
  end

  always_comb begin
    unique case (reg_addr)
      SEL_CAUSE: reg_rdata = {{(DATA_W-NSRC){1'b0}}, cause_q};
      SEL_MASK:  reg_rdata = mask_q;
      SEL_FORCE: reg_rdata = '0;
      default:   reg_rdata = coal_q;
    endcase
  end

  AST_FORCE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(force_vec)); // R3

endmodule

// File: rtl/irqc_cause_bank.sv
module irqc_cause_bank #(
  parameter int NSRC = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_pulse,
  input  logic [NSRC-1:0] force_vec,
  input  logic [NSRC-1:0] w1c_vec,
  input  logic [NSRC-1:0] mask_src,
  input  logic [NSRC-1:0] unmask_vec,
  output logic [NSRC-1:0] cause_q,
  output logic [NSRC-1:0] arrivals
);
  logic [NSRC-1:0] set_vec;
  assign set_vec = evt_pulse | force_vec;

  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cause_q[g] <= 1'b0;
      else if (set_vec[g]) cause_q[g] <= 1'b1;
      else if (w1c_vec[g]) cause_q[g] <= 1'b0;
    end
    // A new unmasked event, or an already set bit being unmasked.
    assign arrivals[g] = (set_vec[g] & ~mask_src[g]) | (cause_q[g] & unmask_vec[g]);
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & $past(w1c_vec & ~set_vec)) == '0)); // R1
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & $past(set_vec)) == $past(set_vec))); // R5

endmodule

// File: rtl/irqc_coalescer.sv
module irqc_coalescer
  import irqc_pkg::*;
#(
  parameter int NSRC  = 12,
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  arrivals,
  input  logic             us_tick,
  input  logic [LIM_W-1:0] max_cnt,
  input  logic [LIM_W-1:0] max_dly,
  output logic             irq
);
  logic [LIM_W:0]   cnt_q, cnt_sum, tmr_next;
  logic [LIM_W-1:0] tmr_q;
  logic [5:0]       n_arr;
  logic             pending, hit_count, hit_time, fire;

  assign n_arr     = count_ones(32'(arrivals));
  assign pending   = (cnt_q != '0);
  assign cnt_sum   = cnt_q + (LIM_W+1)'(n_arr);
  assign tmr_next  = {1'b0, tmr_q} + 1'b1;
  assign hit_count = (cnt_sum >= eff_limit(max_cnt));
  assign hit_time  = pending && us_tick && (tmr_next >= eff_limit(max_dly));
  assign fire      = hit_count || hit_time;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmr_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= fire;
      if (fire) begin
        cnt_q <= '0;
        tmr_q <= '0;
      end else begin
        cnt_q <= cnt_sum;
        if (!pending)     tmr_q <= '0;
        else if (us_tick) tmr_q <= tmr_next[LIM_W-1:0];
      end
    end
  end

  AST_COUNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < eff_limit($past(max_cnt))); // R6
  AST_TIME_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(n_arr) == 6'd0) |-> ($past(us_tick) && $past(cnt_q) != '0)); // R7
  AST_IRQ_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt_q == '0 && tmr_q == '0)); // R8
  AST_IDLE_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (tmr_q == '0)); // R7

endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl #(
  parameter int NSRC   = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]   evt_pulse,
  input  logic              us_tick,
  output logic              irq
);
  localparam int LIM_W = DATA_W / 2;

  logic [NSRC-1:0]  cause_q, w1c_vec, force_vec, mask_src, unmask_vec, arrivals;
  logic [LIM_W-1:0] max_cnt, max_dly;

  irqc_regs #(.NSRC(NSRC), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cause_q(cause_q), .reg_rdata(reg_rdata),
    .w1c_vec(w1c_vec), .force_vec(force_vec), .mask_src(mask_src),
    .unmask_vec(unmask_vec), .max_cnt(max_cnt), .max_dly(max_dly)
  );

  irqc_cause_bank #(.NSRC(NSRC)) u_cause (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .force_vec(force_vec),
    .w1c_vec(w1c_vec), .mask_src(mask_src), .unmask_vec(unmask_vec),
    .cause_q(cause_q), .arrivals(arrivals)
  );

  irqc_coalescer #(.NSRC(NSRC), .LIM_W(LIM_W)) u_coal (
    .clk(clk), .rst_n(rst_n), .arrivals(arrivals), .us_tick(us_tick),
    .max_cnt(max_cnt), .max_dly(max_dly), .irq(irq)
  );

endmodule

// File: tb/test_irq_coalesce_ctrl.sv
`timescale 1ns/1ps
module test_irq_coalesce_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] evt_pulse = '0;
  logic        us_tick = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_coalesce_ctrl i_irq_coalesce_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .us_tick(us_tick), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic cyc(input logic [11:0] e, input logic t, output logic got);
    evt_pulse = e; us_tick = t;
    @(negedge clk);
    evt_pulse = '0; us_tick = 1'b0;
    got = irq;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset values
    rd(2'd0, d); chk(d == 32'h0, "R1 cause reset", d, 32'h0);
    rd(2'd1, d); chk(d == 32'hFFFF_FFFF, "R2 mask reset", d, 32'hFFFF_FFFF);
    rd(2'd2, d); chk(d == 32'h0, "R3 force reads zero", d, 32'h0);
    rd(2'd3, d); chk(d == 32'h0001_0001, "R4 coalesce reset", d, 32'h0001_0001);
    chk(irq == 1'b0, "R10 irq low at reset", {31'd0, irq}, 32'h0);

    // R2: masked events latch but never interrupt
    cyc(12'h004, 1'b0, g); chk(g == 1'b0, "R2 masked event no irq", {31'd0, g}, 0);
    rd(2'd0, d); chk(d == 32'h4, "R2 masked event latches", d, 32'h4);
    // R9: unmasking a set bit counts as an event (count limit 1)
    wr(2'd1, 32'hFFFF_FFFB); chk(irq == 1'b1, "R9 unmask counts", {31'd0, irq}, 1);
    cyc(12'h0, 1'b0, g); chk(g == 1'b0, "R10 single-cycle pulse", {31'd0, g}, 0);
    rd(2'd1, d); chk(d == 32'hFFFF_FFFB, "R2 mask readback", d, 32'hFFFF_FFFB);

    // R1: partial acknowledge and reserved bits
    wr(2'd1, 32'hFFFF_FFFF);
    cyc(12'h007, 1'b0, g);
    wr(2'd0, 32'hFFFF_F005);
    rd(2'd0, d); chk(d == 32'h2, "R1 w1c selective", d, 32'h2);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk(d == 32'h0, "R1 w1c all", d, 32'h0);

    // R3: force sweep over every position with all sources masked
    for (int n = 0; n < 16; n++) begin
      logic [31:0] e;
      e = (n < 12) ? (32'h1 << n) : 32'h0;
      wr(2'd2, n);
      chk(irq == 1'b0, "R3 masked force no irq", {31'd0, irq}, 0);
      rd(2'd0, d); chk(d == e, "R3 force sets bit", d, e);
      wr(2'd0, 32'hFFFF_FFFF);
    end
    wr(2'd1, 32'h0);
    wr(2'd2, 32'd5); chk(irq == 1'b1, "R3 force counts as event", {31'd0, irq}, 1);
    wr(2'd0, 32'hFFFF_FFFF);

    // R6: count-limit sweep, delay long
    for (int n = 0; n < 7; n++) begin
      int lim;
      lim = (n == 0) ? 1 : n;
      wr(2'd3, {16'(n), 16'd1000});
      for (int k = 1; k <= lim; k++) begin
        cyc(12'h1 << (k % 12), 1'b0, g);
        chk(g == (k == lim), "R6 count threshold", {31'd0, g}, {31'd0, (k == lim)});
      end
    end
    // R6/R8: several events per cycle, absorption on fire
    wr(2'd3, {16'd3, 16'd1000});
    cyc(12'h007, 1'b0, g); chk(g == 1'b1, "R6 three in one cycle", {31'd0, g}, 1);
    wr(2'd3, {16'd5, 16'd1000});
    cyc(12'h070, 1'b0, g); chk(g == 1'b0, "R6 sum 3 of 5", {31'd0, g}, 0);
    cyc(12'h700, 1'b0, g); chk(g == 1'b1, "R6 sum 6 reaches 5", {31'd0, g}, 1);
    cyc(12'h007, 1'b0, g); chk(g == 1'b0, "R8 excess not carried", {31'd0, g}, 0);
    cyc(12'h001, 1'b0, g); chk(g == 1'b0, "R8 count 4 of 5", {31'd0, g}, 0);
    cyc(12'h002, 1'b0, g); chk(g == 1'b1, "R8 count 5 of 5", {31'd0, g}, 1);

    // R7: delay sweep, count limit high
    for (int dly = 0; dly < 5; dly++) begin
      int lim;
      lim = (dly == 0) ? 1 : dly;
      wr(2'd3, {16'd100, 16'(dly)});
      cyc(12'h001, 1'b1, g); chk(g == 1'b0, "R7 tick with first event ignored", {31'd0, g}, 0);
      for (int t = 1; t <= lim; t++) begin
        cyc(12'h0, 1'b0, g); chk(g == 1'b0, "R7 idle no fire", {31'd0, g}, 0);
        cyc(12'h0, 1'b1, g);
        chk(g == (t == lim), "R7 timeout on tick", {31'd0, g}, {31'd0, (t == lim)});
      end
    end
    for (int t = 0; t < 4; t++) begin
      cyc(12'h0, 1'b1, g); chk(g == 1'b0, "R7 ticks idle with nothing pending", {31'd0, g}, 0);
    end

    // R8: count fire restarts the timer
    wr(2'd3, {16'd2, 16'd3});
    cyc(12'h010, 1'b0, g);
    cyc(12'h0, 1'b1, g);
    cyc(12'h0, 1'b1, g); chk(g == 1'b0, "R8 two ticks of three", {31'd0, g}, 0);
    cyc(12'h020, 1'b0, g); chk(g == 1'b1, "R8 count fires first", {31'd0, g}, 1);
    cyc(12'h040, 1'b0, g);
    cyc(12'h0, 1'b1, g);
    cyc(12'h0, 1'b1, g); chk(g == 1'b0, "R8 timer restarted", {31'd0, g}, 0);
    cyc(12'h0, 1'b1, g); chk(g == 1'b1, "R8 full delay after restart", {31'd0, g}, 1);

    // R5: event and acknowledge of the same bit in one cycle
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'hFFFF_FFFF);
    cyc(12'h300, 1'b0, g);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_0300; evt_pulse = 12'h100;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; evt_pulse = '0;
    rd(2'd0, d); chk(d == 32'h100, "R5 event wins over clear", d, 32'h100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule